// File: doc/BRIEF.md
# Debug Text Port with Line Capture

This block is a small memory-mapped debug peripheral for boot firmware. Firmware writes characters one at a time to a character offset; the block collects them into a line buffer and, on a line-feed, hands the whole line to a downstream byte stream (for example a trace collector or a simulation console). Carriage returns are dropped, so firmware may send either LF or CR LF line endings. Empty lines produce nothing on the stream.

A second write offset captures a 4-bit power-on self-test progress code. The code is kept on a dedicated output so board logic or a debugger can watch boot progress. Reads are trivial: one status offset always reports both serial buffers empty, and every other offset reads as all ones. This lets firmware that polls for transmit space proceed at once.

Writes finish in the cycle they are presented. The one exception is a character write that arrives while a completed line is still draining; that write is held off through `bus_ready_o` until the last byte of the line has been taken.

Top module: `dbg_text_port`

## Requirements
- R1: A read at offset 0x21 returns 0x0000000C (bit 2 = receive buffer empty, bit 3 = transmit buffer empty) combinationally in the same cycle.
- R2: A read at any offset other than 0x21 returns 0xFFFFFFFF in the same cycle.
- R3: A write at offset 0x23 whose low byte is 0x0D is discarded: it neither adds to nor clears the line buffer.
- R4: A write at offset 0x23 whose low byte is 0x0A, with a non-empty line buffer, streams the buffered bytes in write order, `line_last_o` high on the final byte only, and leaves the buffer empty.
- R5: A write at offset 0x23 whose low byte is 0x0A with an empty line buffer produces no stream output.
- R6: A write at offset 0x23 with any other low byte appends that byte to the line buffer; bits above bit 7 are ignored.
- R7: The line buffer holds LINE_LEN (default 80) characters; further characters are dropped until the next line-feed, which emits exactly LINE_LEN bytes.
- R8: The stream transfers one byte per cycle when `line_valid_o` and `line_ready_i` are both high; while valid is high and ready low, valid, data and last hold.
- R9: While a line is on the stream, every write at offset 0x23 sees `bus_ready_o` low; all other accesses, and character writes while no line is draining, see `bus_ready_o` high and complete that cycle.
- R10: An accepted write at offset 0x41 sets `post_code_o` to bits 3:0 of the write data from the next cycle.
- R11: Writes to offsets other than 0x23 and 0x41 change neither `post_code_o` nor the line buffer nor the stream.
- R12: After reset `post_code_o` is 0, `line_valid_o` is low, `bus_ready_o` is high and the line buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset within the port |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid in the request cycle |
| bus_ready_o | output | 1 | Access completes this cycle |
| line_valid_o | output | 1 | Stream byte valid |
| line_data_o | output | 8 | Stream byte |
| line_last_o | output | 1 | Final byte of a line |
| line_ready_i | input | 1 | Stream sink accepts the byte |
| post_code_o | output | 4 | Captured self-test code |

## Verification
The assertions take for granted that a requester whose write is stalled keeps the same request asserted until `bus_ready_o` rises, and that `line_ready_i` is a plain sink decision independent of the write bus. The stimulus changes requests only a fixed time after a clock edge, holds each stalled character write until it is accepted, and drives the sink ready either constantly high or from a pseudo-random sequence, so back-pressure lands both mid-line and on the final byte. A behavioural model built on queues predicts every output each cycle, including stalls caused by writing while a line drains.

// File: rtl/dbg_text_port_pkg.sv
package dbg_text_port_pkg;
  localparam logic [7:0]  OFS_STATUS = 8'h21;
  localparam logic [7:0]  OFS_CHAR   = 8'h23;
  localparam logic [7:0]  OFS_POST   = 8'h41;
  localparam logic [31:0] STATUS_VAL = 32'h0000_000C;
  localparam logic [7:0]  CH_CR      = 8'h0D;
  localparam logic [7:0]  CH_LF      = 8'h0A;
endpackage

// File: rtl/dbg_port_decode.sv
module dbg_port_decode
  import dbg_text_port_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wbyte_i,
  output logic              hit_char_o,
  output logic              hit_post_o,
  output logic              is_cr_o,
  output logic              is_lf_o,
  output logic [DATA_W-1:0] rdata_o
);
  assign hit_char_o = (addr_i == ADDR_W'(OFS_CHAR));
  assign hit_post_o = (addr_i == ADDR_W'(OFS_POST));
  assign is_cr_o    = (wbyte_i == CH_CR);
  assign is_lf_o    = (wbyte_i == CH_LF);

  always_comb begin
    if (addr_i == ADDR_W'(OFS_STATUS)) rdata_o = DATA_W'(STATUS_VAL);
    else                               rdata_o = '1;
  end
endmodule

// File: rtl/dbg_line_buf.sv
module dbg_line_buf #(
  parameter int LINE_LEN = 80
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       push_i,
  input  logic [7:0] byte_i,
  input  logic       flush_i,
  output logic       busy_o,
  output logic       valid_o,
  output logic [7:0] data_o,
  output logic       last_o,
  input  logic       ready_i
);
  localparam int CNT_W = $clog2(LINE_LEN + 1);
  localparam int IDX_W = (LINE_LEN > 1) ? $clog2(LINE_LEN) : 1;

  logic [7:0]       mem_q [LINE_LEN];
  logic [CNT_W-1:0] fill_q, len_q;
  logic [IDX_W-1:0] rd_q;
  logic             drain_q;
  logic             room, pop, end_of_line;

  assign room        = (fill_q < CNT_W'(LINE_LEN));
  assign pop         = drain_q && ready_i;
  assign end_of_line = (CNT_W'(rd_q) + CNT_W'(1)) == len_q;

  // storage needs no reset; only filled slots are ever read
  always_ff @(posedge clk_i) begin
    if (push_i && room) mem_q[fill_q[IDX_W-1:0]] <= byte_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q  <= '0;
      len_q   <= '0;
      rd_q    <= '0;
      drain_q <= 1'b0;
    end else begin
      if (push_i && room) fill_q <= fill_q + CNT_W'(1);
      if (flush_i) begin
        fill_q <= '0;
        if (fill_q != '0) begin
          drain_q <= 1'b1;
          len_q   <= fill_q;
          rd_q    <= '0;
        end
      end
      if (pop) begin
        rd_q <= rd_q + IDX_W'(1);
        if (end_of_line) drain_q <= 1'b0;
      end
    end
  end

  assign busy_o  = drain_q;
  assign valid_o = drain_q;
  assign data_o  = mem_q[rd_q];
  assign last_o  = drain_q && end_of_line;
endmodule

// File: rtl/dbg_text_port.sv
module dbg_text_port
  import dbg_text_port_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int LINE_LEN = 80
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              bus_ready_o,
  output logic              line_valid_o,
  output logic [7:0]        line_data_o,
  output logic              line_last_o,
  input  logic              line_ready_i,
  output logic [3:0]        post_code_o
);
  logic hit_char, hit_post, is_cr, is_lf, busy;
  logic wr_char, push, flush;
  logic [3:0] post_q;
  logic unused_hi;

  assign unused_hi = ^wdata_i[DATA_W-1:8];

  dbg_port_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dec_i (
    .addr_i    (addr_i),
    .wbyte_i   (wdata_i[7:0]),
    .hit_char_o(hit_char),
    .hit_post_o(hit_post),
    .is_cr_o   (is_cr),
    .is_lf_o   (is_lf),
    .rdata_o   (rdata_o)
  );

  assign bus_ready_o = !(req_i && we_i && hit_char && busy);
  assign wr_char     = req_i && we_i && hit_char && !busy;
  assign push        = wr_char && !is_cr && !is_lf;
  assign flush       = wr_char && is_lf;

  dbg_line_buf #(.LINE_LEN(LINE_LEN)) buf_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .byte_i (wdata_i[7:0]),
    .flush_i(flush),
    .busy_o (busy),
    .valid_o(line_valid_o),
    .data_o (line_data_o),
    .last_o (line_last_o),
    .ready_i(line_ready_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         post_q <= 4'h0;
    else if (req_i && we_i && hit_post)  post_q <= wdata_i[3:0];
  end

  assign post_code_o = post_q;
endmodule

// File: rtl/dbg_text_port_chk.sv
module dbg_text_port_chk
  import dbg_text_port_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              bus_ready_o,
  input logic              line_valid_o,
  input logic [7:0]        line_data_o,
  input logic              line_last_o,
  input logic              line_ready_i,
  input logic [3:0]        post_code_o
);
  logic char_wr, post_wr;
  assign char_wr = req_i && we_i && (addr_i == ADDR_W'(OFS_CHAR));
  assign post_wr = req_i && we_i && (addr_i == ADDR_W'(OFS_POST));

  a_r1_status_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == ADDR_W'(OFS_STATUS)) |-> rdata_o == DATA_W'(STATUS_VAL));

  a_r2_other_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i != ADDR_W'(OFS_STATUS)) |-> rdata_o == '1);

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_valid_o && !line_ready_i) |=>
      (line_valid_o && $stable(line_data_o) && $stable(line_last_o)));

  a_r9_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_valid_o && char_wr) |-> !bus_ready_o);

  a_r9_no_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_valid_o |-> bus_ready_o);

  a_r4_last_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_valid_o && line_ready_i && line_last_o) |=> !line_valid_o);

  a_r10_post_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    post_wr |=> post_code_o == $past(wdata_i[3:0]));

  a_r11_post_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !post_wr |=> $stable(post_code_o));
endmodule

bind dbg_text_port dbg_text_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .bus_ready_o (bus_ready_o),
  .line_valid_o(line_valid_o),
  .line_data_o (line_data_o),
  .line_last_o (line_last_o),
  .line_ready_i(line_ready_i),
  .post_code_o (post_code_o)
);

// File: tb/dbg_text_port_tb_top.sv
`timescale 1ns/1ps
module dbg_text_port_tb_top;
  localparam int LINE_LEN = 80;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        bus_ready_o, line_valid_o, line_last_o;
  logic [7:0]  line_data_o;
  logic        line_ready_i = 1'b1;
  logic [3:0]  post_code_o;

  int checks = 0, failures = 0, cycles = 0, dut_pops = 0;
  bit rnd_ready = 0;
  logic [15:0] lfsr = 16'hACE1;

  // reference model state
  byte unsigned line_q[$];
  byte unsigned exp_q[$];
  logic [3:0]   exp_post = 4'h0;

  dbg_text_port #(.LINE_LEN(LINE_LEN)) dut_i (.*);

  always #2 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // model update on the same edge the design samples
  always @(posedge clk_i) begin
    if (rst_ni) begin
      cycles++;
      if (line_valid_o && line_ready_i) dut_pops++;
      if (exp_q.size() > 0 && line_ready_i) void'(exp_q.pop_front());
      else if (req_i && we_i && !(addr_i == 8'h23 && exp_q.size() > 0)) begin
        if (addr_i == 8'h41) exp_post = wdata_i[3:0];
        else if (addr_i == 8'h23) begin
          if (wdata_i[7:0] == 8'h0A) begin
            foreach (line_q[k]) exp_q.push_back(line_q[k]);
            line_q.delete();
          end else if (wdata_i[7:0] != 8'h0D && line_q.size() < LINE_LEN)
            line_q.push_back(wdata_i[7:0]);
        end
      end else if (req_i && we_i && addr_i == 8'h41) exp_post = wdata_i[3:0];
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end
  end

  // sink ready driven away from the edge
  always @(posedge clk_i) begin
    #1 line_ready_i = rnd_ready ? lfsr[0] : 1'b1;
  end

  // compare every cycle, mid-period
  always @(negedge clk_i) begin
    if (rst_ni) begin
      bit drain;
      drain = exp_q.size() > 0;
      chk(line_valid_o == drain, "R4 R5 line_valid", 32'(line_valid_o), 32'(drain));
      if (drain) begin
        chk(line_data_o == exp_q[0], "R3 R6 R7 R8 line_data", 32'(line_data_o), 32'(exp_q[0]));
        chk(line_last_o == (exp_q.size() == 1), "R4 line_last", 32'(line_last_o), 32'(exp_q.size() == 1));
      end
      chk(bus_ready_o == !(req_i && we_i && addr_i == 8'h23 && drain), "R9 bus_ready",
          32'(bus_ready_o), 32'(!(req_i && we_i && addr_i == 8'h23 && drain)));
      chk(post_code_o == exp_post, "R10 R11 post_code", 32'(post_code_o), 32'(exp_post));
      if (req_i && !we_i) begin
        if (addr_i == 8'h21) chk(rdata_o == 32'h0000000C, "R1 status read", rdata_o, 32'h0000000C);
        else                 chk(rdata_o == 32'hFFFFFFFF, "R2 other read", rdata_o, 32'hFFFFFFFF);
      end
      if (cycles > 100000) begin
        failures++;
        $display("FAIL watchdog act=%0d exp<100000", cycles);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  task automatic bus(input bit w, input logic [7:0] a, input logic [31:0] d);
    req_i = 1'b1; we_i = w; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    while (!bus_ready_o) @(negedge clk_i);
    @(posedge clk_i); #1;
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic put_str(input string s);
    for (int i = 0; i < s.len(); i++) bus(1, 8'h23, {24'hABCDEF, s[i]});
  endtask

  task automatic wait_idle();
    while (line_valid_o) @(negedge clk_i);
    @(posedge clk_i); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    // R12 reset state
    chk(post_code_o == 4'h0, "R12 post reset", 32'(post_code_o), 0);
    chk(!line_valid_o, "R12 valid reset", 32'(line_valid_o), 0);
    chk(bus_ready_o, "R12 ready reset", 32'(bus_ready_o), 1);
    @(posedge clk_i); #1;

    // R1 R2 reads
    bus(0, 8'h21, 0); bus(0, 8'h00, 0); bus(0, 8'h23, 0);
    bus(0, 8'h41, 0); bus(0, 8'hFF, 0); bus(0, 8'h20, 0);

    // R10 capture, R11 other writes ignored
    bus(1, 8'h41, 32'hABCD_EF5A);
    bus(1, 8'h40, 32'h3);
    bus(1, 8'h22, 32'h58);
    bus(1, 8'h42, 32'h7);
    // R5 newline on empty buffer
    bus(1, 8'h23, 32'h0A);
    repeat (3) @(posedge clk_i); #1;
    chk(dut_pops == 0, "R5 R11 no stream", dut_pops, 0);

    // R3 R4 R6 line with CR, sink always ready
    put_str("Hi\r!"); bus(1, 8'h23, 32'h1234_560D); bus(1, 8'h23, 32'h0A);
    wait_idle();
    chk(dut_pops == 3, "R3 R4 byte count", dut_pops, 3);

    // R8 R9 back-pressure, writes pushed while draining
    rnd_ready = 1;
    put_str("boot ok"); bus(1, 8'h23, 32'h0A);
    put_str("next"); bus(1, 8'h41, 32'h6); bus(1, 8'h23, 32'h0A);
    bus(1, 8'h23, 32'h0A);
    wait_idle();
    chk(dut_pops == 14, "R8 R9 byte count", dut_pops, 14);

    // R7 overflow: 90 characters, 80 kept
    for (int i = 0; i < 90; i++) bus(1, 8'h23, 32'(8'h30 + (i % 40)));
    bus(1, 8'h23, 32'h0A);
    wait_idle();
    chk(dut_pops == 14 + LINE_LEN, "R7 truncated line length", dut_pops, 14 + LINE_LEN);
    rnd_ready = 0;
    put_str("z"); bus(1, 8'h23, 32'h0A);
    wait_idle();
    chk(dut_pops == 15 + LINE_LEN, "R7 buffer cleared after overflow", dut_pops, 15 + LINE_LEN);

    repeat (4) @(posedge clk_i);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule